// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a two-wire serial slave that holds a bank of sixteen 8-bit adjustment registers for a display deflection controller and reports one status byte. It runs on the system clock. It oversamples the bus clock and data lines, rejects short glitches, and finds START and STOP conditions. It then decodes the device address and acknowledges each byte it accepts.

A master writes by sending the write address, then a sub-address byte, then one or more data bytes. The sub-address moves forward by one after every data byte, so the whole bank can be reloaded in one burst. A read has no sub-address phase. The slave shifts out one status byte made from the lock inputs and six detection flags, then waits out the master's acknowledge bit and goes idle. The register contents appear in parallel on one flat output. Each accepted data byte also gives a one-cycle strobe with its index and value.

Top module: `ctrl_reg_i2c_slave`

## Requirements
- R1: After reset, sda_oe_o is 0 and wr_stb_o is 0. The registers hold these defaults by index: 0x0=0x80 (bit 7 is the horizontal drive enable, on), 0x3=0x80 (bit 7 selects separate sync), 0x5=0xC0 (bit 7 is the vertical ramp enable, on; bits 6:0 hold mid amplitude 0x40), 0x2=0x00, 0xC=0x00, 0xF=0x00, and every other index 0x40.
- R2: The slave acknowledges the address byte 0x8C as a write and 0x8D as a read. It drives SDA low (sda_oe_o=1) during the ninth clock. For any other address it does not acknowledge, and it ignores every byte until the next START.
- R3: In a write, the byte after the address is the sub-address, and only its low 4 bits select the register. The next byte is stored into that register. The slave acknowledges the sub-address and every data byte.
- R4: Each accepted data byte raises wr_stb_o for exactly one clock, with wr_idx_o set to the register index and wr_data_o set to the byte. The matching slice regs_o[8*idx+7:8*idx] then shows the new value.
- R5: Further data bytes without STOP or repeated START go to consecutive registers. The index wraps from 0xF to 0x0.
- R6: A STOP at any point returns the slave to idle and releases SDA. Bytes clocked after it without a new START are not acknowledged and change nothing. A repeated START restarts the address phase.
- R7: A pulse shorter than FILT_CYC clock cycles (default 7, about 56 ns) on SCL or SDA is ignored and does not disturb a transfer in progress.
- R8: After a read address, the slave sends one byte MSB first: bit 7 = 1 when hlock_i is 0, bit 6 = 1 when vlock_i is 0, and bits 5:0 = flags_i. The inputs are captured at the end of the address acknowledge. After the master's acknowledge bit, the slave drives nothing more until the next START.
- R9: A read produces no write strobe and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge or a read bit of 0) |
| hlock_i | input | 1 | 1 when the horizontal loop is locked |
| vlock_i | input | 1 | 1 when the vertical section is locked |
| flags_i | input | 6 | X-ray latch, polarity and sync detection flags for the status byte |
| wr_stb_o | output | 1 | One-cycle pulse per accepted data byte |
| wr_idx_o | output | 4 | Register index of the current strobe |
| wr_data_o | output | 8 | Data byte of the current strobe |
| regs_o | output | 128 | All sixteen registers, index 0 in bits 7:0 |

## Verification
A table of single-register writes mixes in-range sub-addresses, both value extremes and a foreign device address. This separates correct address matching and storage from writes landing in the wrong slot or on the wrong device. A burst that starts at 0xE and crosses the top of the bank shows whether the index advances and wraps. A sub-address with high bits set checks that only the low nibble decodes. Two reads with complementary status patterns expose inverted lock bits or bit-order errors, and an extra byte clocked afterwards shows whether the slave keeps driving after the reply. Separate sequences cover STOP in mid-write, a repeated START between two writes, and bytes sent with deliberate short SCL and SDA glitches.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } eng_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_SUB,
    K_DATA
  } byte_kind_e;

  // power-on value per register index
  function automatic logic [7:0] reg_default(input int unsigned idx);
    logic [7:0] v;
    unique case (idx)
      0:       v = 8'h80;  // drive enable on
      2:       v = 8'h00;
      3:       v = 8'h80;  // separate sync selected
      5:       v = 8'hC0;  // ramp enable on, mid amplitude
      12:      v = 8'h00;
      15:      v = 8'h00;
      default: v = 8'h40;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int   FILT_CYC = 7,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);

  localparam int CNT_W = $clog2(FILT_CYC + 1);

  logic             s1_q, s2_q, filt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= RST_VAL;
      s2_q   <= RST_VAL;
      filt_q <= RST_VAL;
      cnt_q  <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_W'(FILT_CYC - 1)) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  AST_FILT_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(cnt_q) == CNT_W'(FILT_CYC - 1))); // R7
  AST_FILT_FOLLOWS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> (filt_q == $past(s2_q))); // R7

endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // data edges while clock is high mark bus conditions
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_ctl_pkg::*;
#(
  parameter int         SUB_W    = 4,
  parameter logic [6:0] DEV_ADDR = 7'h46
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_i,
  input  logic [7:0]       status_i,
  output logic             sda_oe_o,
  output logic             wr_stb_o,
  output logic [SUB_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);

  localparam logic [7:0] WR_ADDR = {DEV_ADDR, 1'b0};
  localparam logic [7:0] RD_ADDR = {DEV_ADDR, 1'b1};

  eng_state_e       state_q;
  byte_kind_e       kind_q;
  logic [3:0]       cnt_q;
  logic [7:0]       sh_q, tx_q, dat_q;
  logic [SUB_W-1:0] sub_q, idx_q;
  logic             rd_q, oe_q, stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= K_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      dat_q   <= '0;
      sub_q   <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        rd_q    <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_RX;
        kind_q  <= K_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
        rd_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise_i && cnt_q != 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              unique case (kind_q)
                K_ADDR: begin
                  if (sh_q == WR_ADDR) begin
                    oe_q    <= 1'b1;
                    kind_q  <= K_SUB;
                    state_q <= ST_RX_ACK;
                  end else if (sh_q == RD_ADDR) begin
                    oe_q    <= 1'b1;
                    rd_q    <= 1'b1;
                    state_q <= ST_RX_ACK;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                K_SUB: begin
                  sub_q   <= sh_q[SUB_W-1:0];
                  kind_q  <= K_DATA;
                  oe_q    <= 1'b1;
                  state_q <= ST_RX_ACK;
                end
                default: begin
                  stb_q   <= 1'b1;
                  idx_q   <= sub_q;
                  dat_q   <= sh_q;
                  sub_q   <= sub_q + 1'b1;
                  oe_q    <= 1'b1;
                  state_q <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rd_q) begin
                tx_q    <= status_i;
                oe_q    <= ~status_i[7];
                state_q <= ST_TX;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == 4'd7) begin
                oe_q    <= 1'b0;
                state_q <= ST_TX_ACK;
              end else begin
                tx_q  <= {tx_q[6:0], 1'b0};
                oe_q  <= ~tx_q[6];
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            // master drives its acknowledge in this bit; release afterwards
            if (scl_fall_i) state_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_stb_o  = stb_q;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = dat_q;

  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sda_oe_o && state_q == ST_IDLE)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o); // R6
  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o); // R4
  AST_SUB_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (sub_q == SUB_W'(wr_idx_o + 1'b1))); // R5
  AST_READ_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |-> !wr_stb_o); // R9

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_ctl_pkg::*;
#(
  parameter int SUB_W = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_stb_i,
  input  logic [SUB_W-1:0]          wr_idx_i,
  input  logic [7:0]                wr_data_i,
  output logic [(2**SUB_W)*8-1:0]   bank_o
);

  localparam int NUM_REGS = 2 ** SUB_W;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    val_q <= reg_default(i);
      else if (wr_stb_i && wr_idx_i == SUB_W'(i))     val_q <= wr_data_i;
    end
    assign bank_o[i*8 +: 8] = val_q;
  end

  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable(bank_o)); // R9

endmodule

// File: rtl/ctrl_reg_i2c_slave.sv
module ctrl_reg_i2c_slave #(
  parameter int         FILT_CYC = 7,
  parameter int         SUB_W    = 4,
  parameter logic [6:0] DEV_ADDR = 7'h46
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  input  logic                    hlock_i,
  input  logic                    vlock_i,
  input  logic [5:0]              flags_i,
  output logic                    wr_stb_o,
  output logic [SUB_W-1:0]        wr_idx_o,
  output logic [7:0]              wr_data_o,
  output logic [(2**SUB_W)*8-1:0] regs_o
);

  logic [1:0] raw, filt;
  logic       start, stop, scl_rise, scl_fall;
  logic [7:0] status;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .filt_o(filt[g])
    );
  end

  i2c_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt[1]),
    .sda_i     (filt[0]),
    .start_o   (start),
    .stop_o    (stop),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  // lock bits report 1 when not locked
  assign status = {~hlock_i, ~vlock_i, flags_i};

  i2c_byte_engine #(.SUB_W(SUB_W), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .stop_i    (stop),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_i     (filt[0]),
    .status_i  (status),
    .sda_oe_o  (sda_oe_o),
    .wr_stb_o  (wr_stb_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o)
  );

  i2c_reg_bank #(.SUB_W(SUB_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (wr_stb_o),
    .wr_idx_i (wr_idx_o),
    .wr_data_i(wr_data_o),
    .bank_o   (regs_o)
  );

endmodule

// File: tb/ctrl_reg_i2c_slave_bench.sv
module ctrl_reg_i2c_slave_bench;

  localparam int Q = 25;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         scl_m = 1'b1, sda_m = 1'b1;
  logic         sda_line;
  logic         sda_oe_o;
  logic         hlock_i = 1'b1, vlock_i = 1'b1;
  logic [5:0]   flags_i = '0;
  logic         wr_stb_o;
  logic [3:0]   wr_idx_o;
  logic [7:0]   wr_data_o;
  logic [127:0] regs_o;

  int n_chk = 0, n_fail = 0, stb_cnt = 0, stb_long = 0;
  logic stb_prev = 1'b0, done = 1'b0;
  logic [7:0] exp_regs [16];

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe_o;

  ctrl_reg_i2c_slave u_ctrl_reg_i2c_slave (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .hlock_i(hlock_i), .vlock_i(vlock_i), .flags_i(flags_i),
    .wr_stb_o(wr_stb_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .regs_o(regs_o)
  );

  always @(negedge clk) begin
    if (wr_stb_o) stb_cnt <= stb_cnt + 1;
    if (wr_stb_o && stb_prev) stb_long <= stb_long + 1;
    stb_prev <= wr_stb_o;
  end

  function automatic logic [7:0] dflt(input int i);
    case (i)
      0, 3:      return 8'h80;
      5:         return 8'hC0;
      2, 12, 15: return 8'h00;
      default:   return 8'h40;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(Q); sda_m = 1'b0; cyc(Q); scl_m = 1'b0; cyc(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; cyc(Q); scl_m = 1'b1; cyc(Q); sda_m = 1'b1; cyc(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; cyc(Q); scl_m = 1'b1; cyc(2*Q); scl_m = 1'b0; cyc(Q);
  endtask

  task automatic put_bit_g(input logic b);
    sda_m = b; cyc(Q); scl_m = 1'b1; cyc(10);
    scl_m = 1'b0; cyc(3); scl_m = 1'b1; cyc(10);
    sda_m = ~b; cyc(3); sda_m = b; cyc(24);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; cyc(Q); scl_m = 1'b1; cyc(Q); b = sda_line; cyc(Q); scl_m = 1'b0; cyc(Q);
  endtask

  task automatic send(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack);
  endtask

  task automatic send_g(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit_g(d[i]);
    get_bit(ack);
  endtask

  task automatic recv(output logic [7:0] d, input logic nack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nack);
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < 16; i++) chk(req, $sformatf("reg %0d", i), 32'(regs_o[i*8 +: 8]), 32'(exp_regs[i]));
  endtask

  // {ack expected, address byte, sub-address, data}
  localparam logic [24:0] WR_TBL [0:5] = '{
    {1'b1, 8'h8C, 8'h01, 8'h5A},
    {1'b1, 8'h8C, 8'h06, 8'hA5},
    {1'b1, 8'h8C, 8'h0F, 8'hFF},
    {1'b1, 8'h8C, 8'h00, 8'h00},
    {1'b0, 8'h8E, 8'h02, 8'h77},
    {1'b1, 8'h8C, 8'h0C, 8'h3C}
  };

  initial begin
    logic       ack;
    logic [7:0] rb;
    int         s0;

    cyc(5); rst_ni = 1'b1; cyc(5);
    for (int i = 0; i < 16; i++) exp_regs[i] = dflt(i);
    chk("R1", "sda_oe after reset", 32'(sda_oe_o), 32'd0);
    chk("R1", "wr_stb after reset", 32'(wr_stb_o), 32'd0);
    chk_bank("R1");

    // table of single writes (R2, R3, R4)
    for (int t = 0; t < 6; t++) begin
      logic [24:0] e;
      e = WR_TBL[t];
      s0 = stb_cnt;
      bus_start();
      send(e[23:16], ack); chk("R2", $sformatf("addr ack row %0d", t), 32'(ack), 32'(!e[24]));
      send(e[15:8], ack);  chk("R3", $sformatf("sub ack row %0d", t), 32'(ack), 32'(!e[24]));
      send(e[7:0], ack);   chk("R3", $sformatf("data ack row %0d", t), 32'(ack), 32'(!e[24]));
      bus_stop();
      if (e[24]) exp_regs[e[11:8]] = e[7:0];
      chk("R4", $sformatf("strobes row %0d", t), 32'(stb_cnt - s0), 32'(e[24]));
      chk_bank("R4");
    end

    // burst crossing the top of the bank (R5)
    s0 = stb_cnt;
    bus_start();
    send(8'h8C, ack); send(8'h0E, ack);
    send(8'hA1, ack); send(8'hB2, ack); send(8'hC3, ack); send(8'hD4, ack);
    chk("R5", "last burst ack", 32'(ack), 32'd0);
    bus_stop();
    exp_regs[14] = 8'hA1; exp_regs[15] = 8'hB2; exp_regs[0] = 8'hC3; exp_regs[1] = 8'hD4;
    chk("R5", "burst strobes", 32'(stb_cnt - s0), 32'd4);
    chk("R4", "last strobe index", 32'(wr_idx_o), 32'd1);
    chk("R4", "last strobe data", 32'(wr_data_o), 32'hD4);
    chk_bank("R5");

    // upper sub-address bits ignored (R3)
    bus_start(); send(8'h8C, ack); send(8'h37, ack); send(8'h9E, ack); bus_stop();
    exp_regs[7] = 8'h9E;
    chk("R3", "reg 7 via sub 0x37", 32'(regs_o[7*8 +: 8]), 32'h9E);

    // reads (R8, R9)
    s0 = stb_cnt;
    hlock_i = 1'b1; vlock_i = 1'b0; flags_i = 6'b101001;
    bus_start(); send(8'h8D, ack);
    chk("R2", "read addr ack", 32'(ack), 32'd0);
    recv(rb, 1'b0);
    chk("R8", "status A", 32'(rb), 32'h69);
    recv(rb, 1'b1);
    chk("R8", "bus idle after reply", 32'(rb), 32'hFF);
    bus_stop();
    hlock_i = 1'b0; vlock_i = 1'b1; flags_i = 6'b010110;
    bus_start(); send(8'h8D, ack); recv(rb, 1'b1); bus_stop();
    chk("R8", "status B", 32'(rb), 32'h96);
    chk("R9", "no strobe on read", 32'(stb_cnt - s0), 32'd0);
    chk_bank("R9");

    // STOP aborts, later bytes ignored (R6)
    s0 = stb_cnt;
    bus_start(); send(8'h8C, ack); send(8'h02, ack); bus_stop();
    chk("R6", "sda released after stop", 32'(sda_oe_o), 32'd0);
    send(8'h55, ack);
    chk("R6", "no ack without start", 32'(ack), 32'd1);
    bus_stop();
    chk("R6", "no strobe after stop", 32'(stb_cnt - s0), 32'd0);
    chk("R6", "reg 2 untouched", 32'(regs_o[2*8 +: 8]), 32'(exp_regs[2]));

    // repeated START (R6)
    bus_start(); send(8'h8C, ack); send(8'h04, ack); send(8'h11, ack);
    bus_start(); send(8'h8C, ack);
    chk("R6", "ack after repeated start", 32'(ack), 32'd0);
    send(8'h09, ack); send(8'h22, ack); bus_stop();
    exp_regs[4] = 8'h11; exp_regs[9] = 8'h22;
    chk_bank("R6");

    // glitches on both lines (R7)
    s0 = stb_cnt;
    bus_start(); send(8'h8C, ack);
    send_g(8'h0B, ack); chk("R7", "sub ack with glitches", 32'(ack), 32'd0);
    send_g(8'h96, ack); chk("R7", "data ack with glitches", 32'(ack), 32'd0);
    bus_stop();
    exp_regs[11] = 8'h96;
    chk("R7", "strobes with glitches", 32'(stb_cnt - s0), 32'd1);
    chk_bank("R7");

    chk("R4", "strobe width over run", 32'(stb_long), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule